// File: doc/BRIEF.md
# Reconfigurable Region Freeze Controller

This block sits between the static part of a chip and a region whose logic can be replaced while the rest keeps running. Software talks to it over a small 32-bit register bus. To isolate the region it asks for a freeze. Once the freeze has settled it may hold the region in reset while new logic is loaded. It then asks for an unfreeze to bring the region back. The block drives two signals toward the region: a freeze level and a region reset level.

Each request waits a programmable number of cycles before it is acknowledged. Completion shows up as two status flags, one meaning "frozen" and one meaning "running". A request that does not fit the current state is refused. It leaves a mark in a sticky register that software clears by writing a one. A read-only identification word lets software check which register layout it is talking to.

Top module: `frz_bridge_ctl`

## Requirements
- R1: After reset, regionFreeze and regionReset are low, status reads 2, control reads 0 and the illegal register reads 0.
- R2: Registers are decoded on byte address bits [ADDR_W-1:2]: status at 0, control at 4, illegal at 8, version at 12. Version reads 0xAD000003 when LONG_VERSION=1 and 2 otherwise. regRdData is 0 while regRdEn is low.
- R3: Status bit 0 set means frozen and bit 1 set means running. The two are never set together, and both are clear while a transition settles.
- R4: Control bits [2:0] read back the last accepted write: bit 0 is freeze, bit 1 is region reset, bit 2 is unfreeze. Writing 0 is always accepted and leaves the status unchanged.
- R5: A freeze request (control 1) while running raises regionFreeze and clears status bit 1 on the accepting edge. Status bit 0 sets SETTLE_CYC cycles after that edge.
- R6: regionReset is high exactly while the region is frozen and control bit 1 is set.
- R7: An unfreeze request (control 4) while frozen drops regionReset on the accepting edge. regionFreeze falls and the status goes from 1 to 2 SETTLE_CYC cycles after that edge.
- R8: These requests are illegal: freeze while not running, unfreeze while not frozen, reset while not frozen, reset together with unfreeze, and freeze together with unfreeze. An illegal request sets illegal bit 0 and changes neither the control register, the status nor the outputs.
- R9: The illegal register stays set until a write to offset 8 with data bit 0 at 1. A write there with bit 0 at 0 has no effect.
- R10: Any non-zero control write while a freeze or unfreeze is still settling is illegal, and the transition still completes on time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | ADDR_W | Byte address of the register access |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| regWrData | input | 32 | Write data |
| regRdEn | input | 1 | Read enable |
| regRdData | output | 32 | Read data, combinational, zero when not reading |
| regionFreeze | output | 1 | Isolates the reconfigurable region while high |
| regionReset | output | 1 | Holds the reconfigurable region in reset while high |

## Verification
All eight control-write values are swept from both stable states, running and frozen. The legality of each and its effect on status, control readback and both outputs are computed arithmetically. This tells a correctly refused request apart from one that is silently taken, and it catches a reset that escapes while running. Freeze and unfreeze are timed cycle by cycle against SETTLE_CYC, so an acknowledge that comes one cycle early or late is caught. Writes made during the settle window, and both data values written to the illegal register, show which writes may change the sticky flag and the transition, and which may not.

// File: rtl/frz_pkg.sv
package frz_pkg;

  typedef enum logic [1:0] {
    ST_RUN      = 2'd0,
    ST_FREEZING = 2'd1,
    ST_FROZEN   = 2'd2,
    ST_THAWING  = 2'd3
  } frzState_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic takeFreeze;
    logic takeThaw;
    logic acceptCtl;
    logic flagIllegal;
  } frzStrobe_t;

  localparam int WORD_STATUS = 0;
  localparam int WORD_CTRL   = 1;
  localparam int WORD_ILL    = 2;
  localparam int WORD_VER    = 3;

  localparam int BIT_FREEZE = 0;
  localparam int BIT_RESET  = 1;
  localparam int BIT_THAW   = 2;

endpackage

// File: rtl/frz_datapath.sv
module frz_datapath
  import frz_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int SETTLE_CYC   = 4,
  parameter bit LONG_VERSION = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  input  logic              regRdEn,
  input  frzStrobe_t        strobe,
  input  logic              stFrozen,
  input  logic              stRunning,
  output logic [31:0]       regRdData,
  output logic              ctlWrite,
  output logic [2:0]        reqBits,
  output logic              settleDone,
  output logic [2:0]        ctrlBits,
  output logic              illSticky
);

  localparam int IDX_W = ADDR_W - 2;
  localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYC - 1);
  localparam logic [31:0] VER_VALUE = LONG_VERSION ? 32'hAD00_0003 : 32'd2;

  logic [IDX_W-1:0] wordIdx;
  logic             illClear;
  logic [CNT_W-1:0] settleCnt;

  assign wordIdx  = regAddr[ADDR_W-1:2];
  assign ctlWrite = regWrEn && (wordIdx == IDX_W'(WORD_CTRL));
  assign illClear = regWrEn && (wordIdx == IDX_W'(WORD_ILL)) && regWrData[0];
  assign reqBits  = regWrData[2:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlBits <= '0;
    end else if (strobe.acceptCtl) begin
      ctrlBits <= reqBits;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      illSticky <= 1'b0;
    end else if (strobe.flagIllegal) begin
      illSticky <= 1'b1;
    end else if (illClear) begin
      illSticky <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      settleCnt <= '0;
    end else if (strobe.takeFreeze || strobe.takeThaw) begin
      settleCnt <= CNT_LOAD;
    end else if (settleCnt != '0) begin
      settleCnt <= settleCnt - 1'b1;
    end
  end

  assign settleDone = (settleCnt == '0);

  always_comb begin
    regRdData = '0;
    if (regRdEn) begin
      unique case (wordIdx)
        IDX_W'(WORD_STATUS): regRdData = {30'd0, stRunning, stFrozen};
        IDX_W'(WORD_CTRL):   regRdData = {29'd0, ctrlBits};
        IDX_W'(WORD_ILL):    regRdData = {31'd0, illSticky};
        IDX_W'(WORD_VER):    regRdData = VER_VALUE;
        default:             regRdData = '0;
      endcase
    end
  end

endmodule

// File: rtl/frz_ctrl.sv
module frz_ctrl
  import frz_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctlWrite,
  input  logic [2:0] reqBits,
  input  logic       settleDone,
  output frzStrobe_t strobe,
  output logic       stFrozen,
  output logic       stRunning,
  output logic       regionFreeze
);

  frzState_e state, stateNext;
  logic      wantFreeze, wantReset, wantThaw;
  logic      isBad;

  assign wantFreeze = reqBits[BIT_FREEZE];
  assign wantReset  = reqBits[BIT_RESET];
  assign wantThaw   = reqBits[BIT_THAW];

  assign stRunning    = (state == ST_RUN);
  assign stFrozen     = (state == ST_FROZEN);
  assign regionFreeze = (state != ST_RUN);

  always_comb begin
    isBad = (wantFreeze && wantThaw)
         || (wantFreeze && !stRunning)
         || (wantThaw && !stFrozen)
         || (wantReset && (!stFrozen || wantThaw));
    strobe.flagIllegal = ctlWrite && isBad;
    strobe.acceptCtl   = ctlWrite && !isBad;
    strobe.takeFreeze  = strobe.acceptCtl && wantFreeze;
    strobe.takeThaw    = strobe.acceptCtl && wantThaw;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_RUN:      if (strobe.takeFreeze) stateNext = ST_FREEZING;
      ST_FREEZING: if (settleDone) stateNext = ST_FROZEN;
      ST_FROZEN:   if (strobe.takeThaw) stateNext = ST_THAWING;
      ST_THAWING:  if (settleDone) stateNext = ST_RUN;
      default:     stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end

endmodule

// File: rtl/frz_bridge_ctl.sv
module frz_bridge_ctl
  import frz_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int SETTLE_CYC   = 4,
  parameter bit LONG_VERSION = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  input  logic              regRdEn,
  output logic [31:0]       regRdData,
  output logic              regionFreeze,
  output logic              regionReset
);

  frzStrobe_t strobe;
  logic       ctlWrite;
  logic [2:0] reqBits;
  logic [2:0] ctrlBits;
  logic       settleDone;
  logic       stFrozen;
  logic       stRunning;
  logic       illSticky;

  frz_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .ctlWrite     (ctlWrite),
    .reqBits      (reqBits),
    .settleDone   (settleDone),
    .strobe       (strobe),
    .stFrozen     (stFrozen),
    .stRunning    (stRunning),
    .regionFreeze (regionFreeze)
  );

  frz_datapath #(
    .ADDR_W       (ADDR_W),
    .SETTLE_CYC   (SETTLE_CYC),
    .LONG_VERSION (LONG_VERSION)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .regAddr    (regAddr),
    .regWrEn    (regWrEn),
    .regWrData  (regWrData),
    .regRdEn    (regRdEn),
    .strobe     (strobe),
    .stFrozen   (stFrozen),
    .stRunning  (stRunning),
    .regRdData  (regRdData),
    .ctlWrite   (ctlWrite),
    .reqBits    (reqBits),
    .settleDone (settleDone),
    .ctrlBits   (ctrlBits),
    .illSticky  (illSticky)
  );

  assign regionReset = stFrozen && ctrlBits[BIT_RESET];

endmodule

// File: rtl/frz_bridge_checker.sv
module frz_bridge_checker #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [31:0]       regWrData,
  input logic              regionFreeze,
  input logic              regionReset,
  input logic              stFrozen,
  input logic              stRunning,
  input logic              illSticky
);

  logic illClrWr;
  assign illClrWr = regWrEn && (regAddr[ADDR_W-1:2] == (ADDR_W-2)'(2)) && regWrData[0];

  AST_STATUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(stFrozen && stRunning)); // R3

  AST_RUN_NO_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    stRunning |-> !regionFreeze); // R3

  AST_RESET_ONLY_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    regionReset |-> (stFrozen && regionFreeze)); // R6

  AST_FREEZE_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stFrozen) |-> $past(regionFreeze)); // R5

  AST_THAW_ENDS_RUNNING: assert property (@(posedge clk) disable iff (!rstN)
    $fell(regionFreeze) |-> stRunning); // R7

  AST_ILLEGAL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (illSticky && !illClrWr) |=> illSticky); // R9

endmodule

bind frz_bridge_ctl frz_bridge_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .regAddr      (regAddr),
  .regWrEn      (regWrEn),
  .regWrData    (regWrData),
  .regionFreeze (regionFreeze),
  .regionReset  (regionReset),
  .stFrozen     (stFrozen),
  .stRunning    (stRunning),
  .illSticky    (illSticky)
);

// File: tb/frz_bridge_ctl_test.sv
module frz_bridge_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 4;
  localparam int SETTLE     = 3;
  localparam bit LONG_VER   = 1'b1;

  logic              clk = 1'b0;
  logic              rstN;
  logic [ADDR_W-1:0] regAddr;
  logic              regWrEn;
  logic [31:0]       regWrData;
  logic              regRdEn;
  logic [31:0]       regRdData;
  logic              regionFreeze;
  logic              regionReset;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  frz_bridge_ctl #(.ADDR_W(ADDR_W), .SETTLE_CYC(SETTLE), .LONG_VERSION(LONG_VER)) uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
    .regionFreeze(regionFreeze), .regionReset(regionReset)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    regAddr = a; regRdEn = 1'b1;
    #1;
    d = regRdData;
    regRdEn = 1'b0;
  endtask

  task automatic toRun();
    logic [31:0] s;
    rd(0, s);
    if (s[0]) begin
      wr(4, 0); wr(4, 4);
      repeat (SETTLE) @(negedge clk);
    end
    wr(4, 0);
  endtask

  task automatic toFrozen();
    toRun();
    wr(4, 1);
    repeat (SETTLE) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rstN = 1'b0; regAddr = '0; regWrEn = 1'b0; regWrData = '0; regRdEn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 freeze", {31'd0, regionFreeze}, 0);
    check("R1 reset", {31'd0, regionReset}, 0);
    rd(0, d); check("R1 status", d, 2);
    rd(4, d); check("R1 control", d, 0);
    rd(8, d); check("R1 illegal", d, 0);

    // R2 version and read gating
    rd(12, d); check("R2 version", d, LONG_VER ? 32'hAD00_0003 : 32'd2);
    regAddr = 12; #1; check("R2 idle read", regRdData, 0);

    // R5 freeze timing
    wr(4, 1);
    check("R5 freeze high", {31'd0, regionFreeze}, 1);
    rd(0, d); check("R5 status settling", d, 0);
    repeat (SETTLE - 1) @(negedge clk);
    rd(0, d); check("R5 not yet done", d, 0);
    @(negedge clk);
    rd(0, d); check("R5 frozen", d, 1);
    rd(4, d); check("R4 control readback", d, 1);

    // R6 region reset while frozen
    wr(4, 2);
    check("R6 reset high", {31'd0, regionReset}, 1);
    wr(4, 0);
    check("R6 reset released", {31'd0, regionReset}, 0);
    rd(0, d); check("R4 withdraw keeps status", d, 1);
    rd(4, d); check("R4 control cleared", d, 0);

    // R7 unfreeze timing
    wr(4, 2);
    wr(4, 4);
    check("R7 reset drops first", {31'd0, regionReset}, 0);
    check("R7 freeze still high", {31'd0, regionFreeze}, 1);
    repeat (SETTLE - 1) @(negedge clk);
    check("R7 freeze before settle", {31'd0, regionFreeze}, 1);
    rd(0, d); check("R7 status settling", d, 0);
    @(negedge clk);
    check("R7 freeze dropped", {31'd0, regionFreeze}, 0);
    rd(0, d); check("R7 running", d, 2);
    wr(4, 0);

    // R10 request during settle window
    wr(4, 1);
    wr(4, 4);
    rd(8, d); check("R10 illegal during settle", d, 1);
    rd(4, d); check("R10 control kept", d, 1);
    wr(4, 0);
    rd(0, d); check("R10 freeze completes", d, 1);

    // R9 sticky clear rules
    wr(8, 0);
    rd(8, d); check("R9 write zero keeps", d, 1);
    wr(0, 1);
    rd(8, d); check("R9 other register keeps", d, 1);
    wr(8, 1);
    rd(8, d); check("R9 write one clears", d, 0);

    // R8 sweep of every control value from both stable states
    for (int st = 0; st < 2; st++) begin
      for (int v = 0; v < 8; v++) begin
        bit run, frz, f, r, u, ill;
        logic [31:0] prevCtl, expStat;
        run = (st == 0); frz = !run;
        f = v[0]; r = v[1]; u = v[2];
        if (run) toRun(); else toFrozen();
        wr(8, 1);
        rd(4, prevCtl);
        ill = (f && u) || (f && !run) || (u && !frz) || (r && (!frz || u));
        wr(4, v);
        expStat = ill ? (run ? 2 : 1) : ((f || u) ? 0 : (run ? 2 : 1));
        rd(8, d); check($sformatf("R8 illegal flag st=%0d v=%0d", st, v), d, {31'd0, ill});
        rd(4, d); check($sformatf("R8 control st=%0d v=%0d", st, v), d, ill ? prevCtl : v);
        rd(0, d); check($sformatf("R8 status st=%0d v=%0d", st, v), d, expStat);
        check($sformatf("R8 freeze st=%0d v=%0d", st, v), {31'd0, regionFreeze},
              {31'd0, frz || (!ill && f)});
        check($sformatf("R6 reset st=%0d v=%0d", st, v), {31'd0, regionReset},
              {31'd0, !ill && frz && (v == 2)});
        if (ill) begin
          repeat (SETTLE + 1) @(negedge clk);
          rd(0, d); check($sformatf("R8 status stays st=%0d v=%0d", st, v), d, run ? 2 : 1);
        end else if (f || u) begin
          repeat (SETTLE) @(negedge clk);
          rd(0, d); check($sformatf("R3 settled st=%0d v=%0d", st, v), d, f ? 1 : 2);
        end
      end
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule